// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block keeps the 64-bit control register that places the memory-mapped PCI Express configuration window in the system address space. Software updates it with byte-enabled configuration writes. Each write that reaches the register also decodes it into an enable, a window size and an aligned base address. The block applies that mapping one clock edge after the write. A write that selects the reserved size code is stored in the register, but it does not change the mapping already in force.

A combinational lookup port takes any 64-bit memory address and reports whether it falls inside the window. On a hit it also splits the offset inside the window into bus, device, function and register number. The applied base, size and enable are brought out so that other logic in the system can see the current mapping.

Top module: `pcie_cfg_window`

## Requirements
- R1: After reset, the register holds the default value 0x0000_0000_B000_0000, and the applied mapping is base 0xB000_0000, size 0x1000_0000 and enable 0.
- R2: Bit 0 of the register is the window enable. While the applied enable is 0, no lookup address hits.
- R3: Register bits [2:1] select the size: 00 gives 256 MiB (0x1000_0000), 01 gives 128 MiB (0x0800_0000), 10 gives 64 MiB (0x0400_0000) and 11 is reserved.
- R4: The applied base keeps register bits [38:28] at 256 MiB, bits [38:27] at 128 MiB and bits [38:26] at 64 MiB. Every other base bit reads 0.
- R5: A write that leaves the reserved size code in the register keeps the previous base, size and enable in force.
- R6: The mapping is recomputed only at the clock edge that samples a register write (cfg_we_i=1, cfg_addr_i[11:3] equal to 0x60>>3, and at least one byte enable set). Writes to other addresses, and writes with all byte enables clear, change nothing.
- R7: A write updates only the register bytes whose enable bit is set. Bit k of cfg_be_i covers data bits [8k+7:8k].
- R8: A lookup hits when the applied enable is 1 and base <= address < base + size. The comparison uses all 64 address bits.
- R9: On a hit, the offset (address - base) is reported as bus = offset[27:20], device = offset[19:15], function = offset[14:12] and register = offset[11:0]. On a miss all four fields are 0.
- R10: len_rsvd_o is 1 while the register holds the reserved size code. The next write that leaves a valid size code clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 12 | Configuration byte address; bits [2:0] are ignored |
| cfg_be_i | input | 8 | Byte enables for the write |
| cfg_wdata_i | input | 64 | Write data |
| lookup_addr_i | input | 64 | Memory address to decode |
| lookup_hit_o | output | 1 | Address lies inside the enabled window |
| lookup_bus_o | output | 8 | Bus number of the offset |
| lookup_dev_o | output | 5 | Device number of the offset |
| lookup_fn_o | output | 3 | Function number of the offset |
| lookup_reg_o | output | 12 | Register offset within the function |
| win_en_o | output | 1 | Applied window enable |
| win_base_o | output | 64 | Applied window base |
| win_size_o | output | 64 | Applied window size in bytes |
| len_rsvd_o | output | 1 | Register holds the reserved size code |

## Verification
The register value and the applied mapping are separate pieces of state. A fault in either one shows up on win_base_o, win_size_o or win_en_o at the first negative edge after the write that exposes it. From there it spreads at once to the combinational lookup outputs. A fault in the reserved-code hold is visible only when a reserved write follows a valid one. A stale register byte is visible only when a later valid write re-applies the whole register. For this reason the tests chain writes: reserved, then a partial write, then a valid write.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  typedef enum logic [1:0] {
    WLEN_256M = 2'b00,
    WLEN_128M = 2'b01,
    WLEN_64M  = 2'b10,
    WLEN_RSVD = 2'b11
  } win_len_e;

  localparam int unsigned LG_LARGEST = 28;

  // log2 of the window size for a valid code
  function automatic int unsigned len_lg(input win_len_e code);
    return LG_LARGEST - int'(code);
  endfunction
endpackage

// File: rtl/pcw_cfg_reg.sv
module pcw_cfg_reg #(
  parameter int unsigned            REG_W   = 64,
  parameter int unsigned            OFS_W   = 12,
  parameter logic [OFS_W-1:0]       REG_OFS = 12'h060,
  parameter logic [REG_W-1:0]       DEF_VAL = 64'h0000_0000_B000_0000,
  localparam int unsigned           BE_W    = REG_W / 8,
  localparam int unsigned           AL_W    = $clog2(BE_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [OFS_W-1:0] wr_addr_i,
  input  logic [BE_W-1:0]  wr_be_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             upd_o,
  output logic [REG_W-1:0] next_o,
  output logic             rsvd_o
);
  import pcw_pkg::*;

  logic [REG_W-1:0] reg_q;
  logic             rsvd_q;
  logic             sel;

  assign sel   = wr_en_i && (wr_addr_i[OFS_W-1:AL_W] == REG_OFS[OFS_W-1:AL_W]);
  assign upd_o = sel && (|wr_be_i);

  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    assign next_o[8*b +: 8] = (sel && wr_be_i[b]) ? wr_data_i[8*b +: 8] : reg_q[8*b +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q  <= DEF_VAL;
      rsvd_q <= (DEF_VAL[2:1] == WLEN_RSVD);
    end else if (upd_o) begin
      reg_q  <= next_o;
      rsvd_q <= (next_o[2:1] == WLEN_RSVD);
    end
  end

  assign rsvd_o = rsvd_q;

  assert_rsvd_rise_on_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsvd_q) |-> $past(upd_o));
  assert_no_be_no_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_be_i == '0) |=> $stable(reg_q));
endmodule

// File: rtl/pcw_map.sv
module pcw_map #(
  parameter int unsigned       ADDR_W  = 64,
  parameter int unsigned       BASE_HI = 38,
  parameter logic [ADDR_W-1:0] DEF_VAL = 64'h0000_0000_B000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [ADDR_W-1:0] val_i,
  output logic              en_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] size_o
);
  import pcw_pkg::*;

  function automatic logic [ADDR_W-1:0] base_mask(input win_len_e code);
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++)
      m[i] = (i >= int'(len_lg(code))) && (i <= int'(BASE_HI));
    return m;
  endfunction

  function automatic logic [ADDR_W-1:0] size_of(input win_len_e code);
    return {{(ADDR_W-1){1'b0}}, 1'b1} << len_lg(code);
  endfunction

  localparam win_len_e          DEF_CODE = win_len_e'(DEF_VAL[2:1]);
  localparam logic [ADDR_W-1:0] DEF_BASE = DEF_VAL & base_mask(DEF_CODE);
  localparam logic [ADDR_W-1:0] DEF_SIZE = size_of(DEF_CODE);

  win_len_e          code;
  logic              valid;
  logic [ADDR_W-1:0] base_d, size_d;

  always_comb begin
    code   = win_len_e'(val_i[2:1]);
    valid  = (code != WLEN_RSVD);
    base_d = val_i & base_mask(code);
    size_d = size_of(code);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= DEF_VAL[0];
      base_o <= DEF_BASE;
      size_o <= DEF_SIZE;
    end else if (upd_i && valid) begin
      en_o   <= val_i[0];
      base_o <= base_d;
      size_o <= size_d;
    end
  end

  assert_rsvd_keeps_map_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && val_i[2:1] == 2'b11) |=> ($stable(base_o) && $stable(size_o) && $stable(en_o)));
  assert_map_only_on_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(base_o) && $stable(size_o) && $stable(en_o)));
  assert_base_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_o & (size_o - 1'b1)) == '0);
  assert_size_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(size_o) && (size_o != '0));
endmodule

// File: rtl/pcw_addr_dec.sv
module pcw_addr_dec #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] size_i,
  output logic              hit_o,
  output logic [7:0]        bus_o,
  output logic [4:0]        dev_o,
  output logic [2:0]        fn_o,
  output logic [11:0]       reg_o
);
  logic [ADDR_W-1:0] off;

  always_comb begin
    off   = addr_i - base_i;
    hit_o = en_i && (addr_i >= base_i) && (off < size_i);
    bus_o = hit_o ? off[27:20] : '0;
    dev_o = hit_o ? off[19:15] : '0;
    fn_o  = hit_o ? off[14:12] : '0;
    reg_o = hit_o ? off[11:0]  : '0;
  end

  assert_hit_needs_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> en_i);
  assert_hit_in_bus_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ({{(ADDR_W-8){1'b0}}, bus_o} < (size_i >> 20)));
endmodule

// File: rtl/pcie_cfg_window.sv
module pcie_cfg_window #(
  parameter int unsigned       ADDR_W  = 64,
  parameter int unsigned       OFS_W   = 12,
  parameter logic [OFS_W-1:0]  REG_OFS = 12'h060,
  parameter int unsigned       BASE_HI = 38,
  parameter logic [ADDR_W-1:0] DEF_VAL = 64'h0000_0000_B000_0000,
  localparam int unsigned      BE_W    = ADDR_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [OFS_W-1:0]  cfg_addr_i,
  input  logic [BE_W-1:0]   cfg_be_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              lookup_hit_o,
  output logic [7:0]        lookup_bus_o,
  output logic [4:0]        lookup_dev_o,
  output logic [2:0]        lookup_fn_o,
  output logic [11:0]       lookup_reg_o,
  output logic              win_en_o,
  output logic [ADDR_W-1:0] win_base_o,
  output logic [ADDR_W-1:0] win_size_o,
  output logic              len_rsvd_o
);
  logic              upd;
  logic [ADDR_W-1:0] next_val;

  pcw_cfg_reg #(.REG_W(ADDR_W), .OFS_W(OFS_W), .REG_OFS(REG_OFS), .DEF_VAL(DEF_VAL)) u_reg (
    .clk_i, .rst_ni,
    .wr_en_i(cfg_we_i), .wr_addr_i(cfg_addr_i), .wr_be_i(cfg_be_i), .wr_data_i(cfg_wdata_i),
    .upd_o(upd), .next_o(next_val), .rsvd_o(len_rsvd_o)
  );

  pcw_map #(.ADDR_W(ADDR_W), .BASE_HI(BASE_HI), .DEF_VAL(DEF_VAL)) u_map (
    .clk_i, .rst_ni, .upd_i(upd), .val_i(next_val),
    .en_o(win_en_o), .base_o(win_base_o), .size_o(win_size_o)
  );

  pcw_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni, .addr_i(lookup_addr_i),
    .en_i(win_en_o), .base_i(win_base_o), .size_i(win_size_o),
    .hit_o(lookup_hit_o), .bus_o(lookup_bus_o), .dev_o(lookup_dev_o),
    .fn_o(lookup_fn_o), .reg_o(lookup_reg_o)
  );
endmodule

// File: tb/pcie_cfg_window_test.sv
module pcie_cfg_window_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] OFS = 12'h060;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  be = '0;
  logic [63:0] wdata = '0;
  logic [63:0] laddr = '0;
  logic        hit, en, rsvd;
  logic [7:0]  bus;
  logic [4:0]  dev;
  logic [2:0]  fn;
  logic [11:0] rg;
  logic [63:0] base, size;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcie_cfg_window uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .lookup_addr_i(laddr), .lookup_hit_o(hit), .lookup_bus_o(bus),
    .lookup_dev_o(dev), .lookup_fn_o(fn), .lookup_reg_o(rg), .win_en_o(en),
    .win_base_o(base), .win_size_o(size), .len_rsvd_o(rsvd)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] b, input logic [63:0] d);
    @(negedge clk); we = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk); we = 1'b0; be = '0;
  endtask

  task automatic map_is(input string req, input logic e, input logic [63:0] b, input logic [63:0] s);
    chk({req, " en"}, {63'd0, en}, {63'd0, e});
    chk({req, " base"}, base, b);
    chk({req, " size"}, size, s);
  endtask

  task automatic look(input logic [63:0] a);
    laddr = a; #1;
  endtask

  task automatic t_reset;
    map_is("R1 reset", 1'b0, 64'hB000_0000, 64'h1000_0000);
    chk("R1 rsvd", {63'd0, rsvd}, 64'd0);
    look(64'hB000_0000);
    chk("R2 disabled no hit", {63'd0, hit}, 64'd0);
  endtask

  task automatic t_lengths;
    wr(OFS, 8'hFF, 64'h0000_00FF_FFFF_FFF9);
    map_is("R3 R4 256M", 1'b1, 64'h0000_007F_F000_0000, 64'h1000_0000);
    wr(OFS, 8'hFF, 64'h0000_00FF_FFFF_FFFB);
    map_is("R3 R4 128M", 1'b1, 64'h0000_007F_F800_0000, 64'h0800_0000);
    wr(OFS, 8'hFF, 64'h0000_00FF_FFFF_FFFD);
    map_is("R3 R4 64M", 1'b1, 64'h0000_007F_FC00_0000, 64'h0400_0000);
  endtask

  task automatic t_enable;
    wr(OFS, 8'hFF, 64'h0000_0000_E000_0000);
    look(64'hE000_0000);
    chk("R2 enable clear", {63'd0, hit}, 64'd0);
    wr(OFS, 8'h01, 64'h0000_0000_0000_0001);
    map_is("R2 enable set", 1'b1, 64'hE000_0000, 64'h1000_0000);
  endtask

  task automatic t_hits;
    look(64'hE000_0000);
    chk("R8 low edge hit", {63'd0, hit}, 64'd1);
    chk("R9 bus zero", {56'd0, bus}, 64'd0);
    look(64'hEFFF_FFFF);
    chk("R8 high edge hit", {63'd0, hit}, 64'd1);
    chk("R9 bus max", {56'd0, bus}, 64'hFF);
    chk("R9 dev max", {59'd0, dev}, 64'h1F);
    chk("R9 fn max", {61'd0, fn}, 64'h7);
    chk("R9 reg max", {52'd0, rg}, 64'hFFF);
    look(64'hF000_0000);
    chk("R8 above miss", {63'd0, hit}, 64'd0);
    look(64'hDFFF_FFFF);
    chk("R8 below miss", {63'd0, hit}, 64'd0);
    chk("R9 fields zero on miss", {bus, dev, fn, rg}, 64'd0);
    look(64'h0000_0100_E000_0000);
    chk("R8 upper bits miss", {63'd0, hit}, 64'd0);
    look(64'hE123_4567);
    chk("R9 split bus", {56'd0, bus}, 64'h12);
    chk("R9 split dev", {59'd0, dev}, 64'h6);
    chk("R9 split fn", {61'd0, fn}, 64'h4);
    chk("R9 split reg", {52'd0, rg}, 64'h567);
  endtask

  task automatic t_ignored;
    wr(12'h068, 8'hFF, 64'h0000_0000_4000_0003);
    map_is("R6 other offset", 1'b1, 64'hE000_0000, 64'h1000_0000);
    wr(OFS, 8'h00, 64'h0000_0000_4000_0003);
    map_is("R6 no byte enable", 1'b1, 64'hE000_0000, 64'h1000_0000);
    wr(OFS, 8'h08, 64'hFFFF_FFFF_C0FF_FFFF);
    map_is("R7 byte3 only", 1'b1, 64'hC000_0000, 64'h1000_0000);
  endtask

  task automatic t_reserved;
    wr(OFS, 8'h01, 64'h0000_0000_0000_0006);
    map_is("R5 reserved hold", 1'b1, 64'hC000_0000, 64'h1000_0000);
    chk("R10 flag set", {63'd0, rsvd}, 64'd1);
    look(64'hC000_1000);
    chk("R5 old window still hits", {63'd0, hit}, 64'd1);
    wr(OFS, 8'h08, 64'h0000_0000_A000_0000);
    map_is("R5 still reserved", 1'b1, 64'hC000_0000, 64'h1000_0000);
    chk("R10 flag kept", {63'd0, rsvd}, 64'd1);
    wr(OFS, 8'h01, 64'h0000_0000_0000_0003);
    map_is("R5 R7 valid reapplies", 1'b1, 64'hA000_0000, 64'h0800_0000);
    chk("R10 flag cleared", {63'd0, rsvd}, 64'd0);
    look(64'hA800_0000);
    chk("R8 128M end miss", {63'd0, hit}, 64'd0);
    look(64'hA7FF_FFFF);
    chk("R8 128M last hit", {63'd0, hit}, 64'd1);
    chk("R9 128M bus", {56'd0, bus}, 64'h7F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_enable();
    t_hits();
    t_ignored();
    t_reserved();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule